// File: doc/BRIEF.md
# Three-State Snooping Coherence Controller

This controller sits between one processor and a single atomic shared bus, and keeps a small direct-mapped write-back cache coherent with its peers. Each line is Invalid, Shared or Modified. Shared is a read-only copy that other caches may also hold. Modified is the only valid, writable copy in the system. The processor presents load, store and evict requests and holds each one until the controller pulses `cpuDone`. The controller requests the bus when it must announce something, and it watches every transaction that other agents put on the bus.

When a peer reads or claims a line this cache holds Modified, the controller places the reply on the bus in that same cycle. It also raises an owner flag so that memory stays silent. A Shared copy that is about to be written is upgraded with a plain invalidate message and no data transfer. The bus command for a request is derived afresh every cycle from the current line state. So an upgrade that loses the bus to a peer's claim on the same line is issued as a read-exclusive once it is granted.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. Any load then needs the bus, and no output is active while the block is idle.
- R2: A load to a line that is absent or Invalid raises `busReq`. On grant it issues a read (command code 1) for the request address. It completes in the cycle a reply (code 5) for that address arrives, and returns the reply data on `cpuRdata`.
- R3: A store to an absent line issues a read-exclusive (code 2). It completes on the reply, and the line becomes Modified and holds the store data.
- R4: A store to a Shared line issues an invalidate (code 3) and completes in the grant cycle without waiting for a reply. The line becomes Modified.
- R5: A load to a Shared or Modified line and a store to a Modified line complete in the cycle they are presented, with no bus request. A store updates the line data.
- R6: Evicting a Shared or Invalid line completes at once, silently, and leaves the line Invalid.
- R7: Evicting a Modified line issues a write-back (code 4) that carries the line address and data. It completes in the grant cycle and leaves the line Invalid.
- R8: A snooped read to a line held Modified makes the block drive a reply with the line data and raise `busOwner` in the same cycle. The line becomes Shared.
- R9: A snooped read-exclusive to a line held Modified produces the same owner reply, and the line becomes Invalid.
- R10: A snooped read-exclusive or invalidate to a Shared line makes it Invalid with no reply.
- R11: Snooped traffic whose tag does not match the resident tag, or that targets an Invalid line, changes nothing and produces no reply.
- R12: A pending upgrade whose line is invalidated by a snooped message before the grant issues a read-exclusive instead of an invalidate. Local commands appear on the bus only while `busGnt` is high.
- R13: A load or store that misses on a line held Modified with another tag first writes the victim back, at address {old tag, index}, and then issues its own read or read-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until done |
| cpuOp | input | 2 | 0 load, 1 store, 2 evict |
| cpuAddr | input | ADDR_W | Request address (low bits index, high bits tag) |
| cpuWdata | input | DATA_W | Store data |
| cpuDone | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Load data, valid with cpuDone |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant |
| busOutValid | output | 1 | This block drives a bus message |
| busOutCmd | output | 3 | Message code: 1 read, 2 read-exclusive, 3 invalidate, 4 write-back, 5 reply |
| busOutAddr | output | ADDR_W | Message address |
| busOutData | output | DATA_W | Message data (write-back or reply) |
| busOwner | output | 1 | Owner responds; memory must not reply |
| snpValid | input | 1 | Message from another agent is on the bus |
| snpCmd | input | 3 | Snooped message code |
| snpAddr | input | ADDR_W | Snooped address |
| snpData | input | DATA_W | Snooped data (reply data for fills) |

## Verification
The checks assume that the bus is atomic. The arbiter never asserts `busGnt` in a cycle that carries a snooped message. The processor holds `cpuReq` and its operands steady until `cpuDone`. No peer sends an invalidate for a line this cache holds Modified, since that would mean two owners. The stimulus grants the bus only while no snoop is driven, delivers each reply in a separate cycle after the grant, and releases the request only in the cycle after completion. The race case is built by placing the conflicting invalidate between the request and the grant.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } lineState_t;

  typedef enum logic [2:0] {
    BC_NONE  = 3'd0,
    BC_RD    = 3'd1,
    BC_RDX   = 3'd2,
    BC_INV   = 3'd3,
    BC_WB    = 3'd4,
    BC_REPLY = 3'd5
  } busCmd_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2
  } cpuOp_t;

  // strobes from a control unit to the line store
  typedef struct packed {
    logic       wrState;
    lineState_t newState;
    logic       wrTag;
    logic       wrData;
    logic       dataFromBus;
  } lineStrobe_t;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [TAG_W-1:0]  newTag,
  input  logic [DATA_W-1:0] cpuWdata,
  input  lineStrobe_t       lclStb,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [DATA_W-1:0] snpData,
  input  lineStrobe_t       snpStb,
  output lineState_t        cpuState,
  output logic [TAG_W-1:0]  cpuTag,
  output logic [DATA_W-1:0] cpuData,
  output lineState_t        snpState,
  output logic [TAG_W-1:0]  snpTag,
  output logic [DATA_W-1:0] snpLineData
);

  lineState_t        stArr   [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  logic [DATA_W-1:0] fillData;
  assign fillData = lclStb.dataFromBus ? snpData : cpuWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stArr[i]   <= LN_INV;
        tagArr[i]  <= '0;
        dataArr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        // snooped downgrades win over local writes to the same line
        if (snpStb.wrState && (snpIdx == IDX_W'(i))) begin
          stArr[i] <= snpStb.newState;
        end else if (lclStb.wrState && (cpuIdx == IDX_W'(i))) begin
          stArr[i] <= lclStb.newState;
        end
        if (lclStb.wrTag && (cpuIdx == IDX_W'(i))) begin
          tagArr[i] <= newTag;
        end
        if (lclStb.wrData && (cpuIdx == IDX_W'(i))) begin
          dataArr[i] <= fillData;
        end
      end
    end
  end

  assign cpuState    = stArr[cpuIdx];
  assign cpuTag      = tagArr[cpuIdx];
  assign cpuData     = dataArr[cpuIdx];
  assign snpState    = stArr[snpIdx];
  assign snpTag      = tagArr[snpIdx];
  assign snpLineData = dataArr[snpIdx];

endmodule

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
  import msi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             snpValid,
  input  logic [2:0]       snpCmd,
  input  logic [TAG_W-1:0] snpAddrTag,
  input  lineState_t       lineState,
  input  logic [TAG_W-1:0] lineTag,
  output lineStrobe_t      snpStb,
  output logic             replyValid
);

  busCmd_t cmd;
  logic    present;

  assign cmd     = busCmd_t'(snpCmd);
  assign present = snpValid && (lineState != LN_INV) && (lineTag == snpAddrTag);

  always_comb begin
    snpStb     = '0;
    replyValid = 1'b0;
    if (present) begin
      case (lineState)
        LN_MOD: begin
          if (cmd == BC_RD) begin
            replyValid      = 1'b1;
            snpStb.wrState  = 1'b1;
            snpStb.newState = LN_SHR;
          end else if (cmd == BC_RDX) begin
            replyValid      = 1'b1;
            snpStb.wrState  = 1'b1;
            snpStb.newState = LN_INV;
          end
        end
        LN_SHR: begin
          if ((cmd == BC_RDX) || (cmd == BC_INV)) begin
            snpStb.wrState  = 1'b1;
            snpStb.newState = LN_INV;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic [1:0]       cpuOp,
  input  logic [TAG_W-1:0] reqTag,
  input  lineState_t       lineState,
  input  logic [TAG_W-1:0] lineTag,
  input  logic             busGnt,
  input  logic             snpValid,
  input  logic [2:0]       snpCmd,
  input  logic             snpHitsReq,
  output lineStrobe_t      lclStb,
  output logic             cpuDone,
  output logic             busReq,
  output logic             issueValid,
  output busCmd_t          issueCmd,
  output logic             issueIsWb
);

  typedef enum logic [1:0] {F_IDLE, F_ARB, F_WAIT} fsm_t;

  fsm_t    fsm, fsmNxt;
  cpuOp_t  op;
  busCmd_t needCmd;
  logic    tagHit;
  logic    dirtyVictim;

  assign op          = cpuOp_t'(cpuOp);
  assign tagHit      = (lineState != LN_INV) && (lineTag == reqTag);
  assign dirtyVictim = (lineState == LN_MOD) && (lineTag != reqTag);

  // bus command needed now, recomputed from the live line state
  always_comb begin
    case (op)
      OP_LOAD:  needCmd = tagHit ? BC_NONE : (dirtyVictim ? BC_WB : BC_RD);
      OP_STORE: begin
        if (tagHit) needCmd = (lineState == LN_MOD) ? BC_NONE : BC_INV;
        else        needCmd = dirtyVictim ? BC_WB : BC_RDX;
      end
      OP_EVICT: needCmd = (tagHit && (lineState == LN_MOD)) ? BC_WB : BC_NONE;
      default:  needCmd = BC_NONE;
    endcase
  end

  assign issueCmd  = needCmd;
  assign issueIsWb = (needCmd == BC_WB);

  always_comb begin
    lclStb     = '0;
    cpuDone    = 1'b0;
    busReq     = 1'b0;
    issueValid = 1'b0;
    fsmNxt     = fsm;
    case (fsm)
      F_IDLE, F_ARB: begin
        if (cpuReq && !snpValid) begin
          if (needCmd == BC_NONE) begin
            cpuDone = 1'b1;
            fsmNxt  = F_IDLE;
            if (op == OP_STORE) lclStb.wrData = 1'b1;
            if ((op == OP_EVICT) && tagHit) begin
              lclStb.wrState  = 1'b1;
              lclStb.newState = LN_INV;
            end
          end else if (fsm == F_IDLE) begin
            fsmNxt = F_ARB;
          end else begin
            busReq = 1'b1;
            if (busGnt) begin
              issueValid = 1'b1;
              case (needCmd)
                BC_WB: begin
                  lclStb.wrState  = 1'b1;
                  lclStb.newState = LN_INV;
                  if (op == OP_EVICT) begin
                    cpuDone = 1'b1;
                    fsmNxt  = F_IDLE;
                  end
                end
                BC_INV: begin
                  lclStb.wrState  = 1'b1;
                  lclStb.newState = LN_MOD;
                  lclStb.wrData   = 1'b1;
                  cpuDone         = 1'b1;
                  fsmNxt          = F_IDLE;
                end
                default: fsmNxt = F_WAIT;
              endcase
            end
          end
        end
      end
      F_WAIT: begin
        if (snpValid && (busCmd_t'(snpCmd) == BC_REPLY) && snpHitsReq) begin
          cpuDone            = 1'b1;
          lclStb.wrState     = 1'b1;
          lclStb.newState    = (op == OP_LOAD) ? LN_SHR : LN_MOD;
          lclStb.wrTag       = 1'b1;
          lclStb.wrData      = 1'b1;
          lclStb.dataFromBus = (op == OP_LOAD);
          fsmNxt             = F_IDLE;
        end
      end
      default: fsmNxt = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsm <= F_IDLE;
    else       fsm <= fsmNxt;
  end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic [1:0]        cpuOp,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busOutValid,
  output logic [2:0]        busOutCmd,
  output logic [ADDR_W-1:0] busOutAddr,
  output logic [DATA_W-1:0] busOutData,
  output logic              busOwner,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] snpData
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpuIdx, snpIdx;
  logic [TAG_W-1:0]  reqTag, snpAddrTag;
  lineState_t        cpuState, snpState;
  logic [TAG_W-1:0]  cpuTag, snpTag;
  logic [DATA_W-1:0] cpuLineData, snpLineData;
  lineStrobe_t       lclStb, snpStb;
  logic              replyValid, issueValid, issueIsWb;
  busCmd_t           issueCmd;
  logic [ADDR_W-1:0] issueAddr;

  assign cpuIdx     = cpuAddr[IDX_W-1:0];
  assign reqTag     = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx     = snpAddr[IDX_W-1:0];
  assign snpAddrTag = snpAddr[ADDR_W-1:IDX_W];

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk(clk), .rstN(rstN),
    .cpuIdx(cpuIdx), .newTag(reqTag), .cpuWdata(cpuWdata), .lclStb(lclStb),
    .snpIdx(snpIdx), .snpData(snpData), .snpStb(snpStb),
    .cpuState(cpuState), .cpuTag(cpuTag), .cpuData(cpuLineData),
    .snpState(snpState), .snpTag(snpTag), .snpLineData(snpLineData)
  );

  msi_snoop_resp #(.TAG_W(TAG_W)) i_snoop (
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddrTag(snpAddrTag),
    .lineState(snpState), .lineTag(snpTag),
    .snpStb(snpStb), .replyValid(replyValid)
  );

  msi_ctrl #(.TAG_W(TAG_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuOp(cpuOp), .reqTag(reqTag),
    .lineState(cpuState), .lineTag(cpuTag),
    .busGnt(busGnt), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpHitsReq(snpAddr == cpuAddr),
    .lclStb(lclStb), .cpuDone(cpuDone), .busReq(busReq),
    .issueValid(issueValid), .issueCmd(issueCmd), .issueIsWb(issueIsWb)
  );

  assign issueAddr   = issueIsWb ? {cpuTag, cpuIdx} : cpuAddr;
  assign cpuRdata    = (lclStb.wrData && lclStb.dataFromBus) ? snpData : cpuLineData;

  assign busOutValid = replyValid || issueValid;
  assign busOutCmd   = replyValid ? BC_REPLY : issueCmd;
  assign busOutAddr  = replyValid ? snpAddr : issueAddr;
  assign busOutData  = replyValid ? snpLineData : cpuLineData;
  assign busOwner    = replyValid;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic [1:0]        cpuOp,
  input logic              cpuDone,
  input logic              busReq,
  input logic              busGnt,
  input logic              busOutValid,
  input logic [2:0]        busOutCmd,
  input logic [ADDR_W-1:0] busOutAddr,
  input logic              busOwner,
  input logic              snpValid,
  input logic [2:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr
);

  AST_ATOMIC_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !(busGnt && snpValid)); // R12

  AST_ISSUE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rstN)
    (busOutValid && (busOutCmd != 3'(BC_REPLY))) |-> busGnt); // R12

  AST_OWNER_IS_REPLY: assert property (@(posedge clk) disable iff (!rstN)
    busOwner |-> (busOutValid && (busOutCmd == 3'(BC_REPLY)))); // R8

  AST_REPLY_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rstN)
    (busOutValid && (busOutCmd == 3'(BC_REPLY))) |->
      (snpValid && ((snpCmd == 3'(BC_RD)) || (snpCmd == 3'(BC_RDX))) && (busOutAddr == snpAddr))); // R9

  AST_INV_COMPLETES: assert property (@(posedge clk) disable iff (!rstN)
    (busOutValid && (busOutCmd == 3'(BC_INV))) |-> (cpuDone && (cpuOp == 2'(OP_STORE)))); // R4

  AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (busOutValid && ((busOutCmd == 3'(BC_RD)) || (busOutCmd == 3'(BC_RDX)))) |=> !busReq); // R2

  AST_DONE_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuReq); // R5

  AST_EVICT_ONLY_WB: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && (cpuOp == 2'(OP_EVICT)) && busOutValid && !busOwner) |-> (busOutCmd == 3'(BC_WB))); // R7

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_msi_snoop_ctrl.sv
module test_msi_snoop_ctrl;

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, EV = 2'd2;
  localparam logic [2:0] CN = 3'd0, CRD = 3'd1, CRX = 3'd2, CIV = 3'd3, CWB = 3'd4, CRP = 3'd5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuReq = 1'b0;
  logic [1:0] cpuOp = '0;
  logic [7:0] cpuAddr = '0, cpuWdata = '0;
  logic       cpuDone;
  logic [7:0] cpuRdata;
  logic       busReq, busGnt = 1'b0;
  logic       busOutValid;
  logic [2:0] busOutCmd;
  logic [7:0] busOutAddr, busOutData;
  logic       busOwner;
  logic       snpValid = 1'b0;
  logic [2:0] snpCmd = '0;
  logic [7:0] snpAddr = '0, snpData = '0;

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  msi_snoop_ctrl i_msi_snoop_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuOp(cpuOp), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGnt(busGnt), .busOutValid(busOutValid),
    .busOutCmd(busOutCmd), .busOutAddr(busOutAddr), .busOutData(busOutData),
    .busOwner(busOwner), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpAddr(snpAddr), .snpData(snpData)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] addr;
    logic [7:0] wd;
    logic [2:0] cmd;
    logic [7:0] bAddr;
    logic [7:0] bData;
    logic [7:0] rep;
    logic [7:0] rd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{LD, 8'h10, 8'h00, CRD, 8'h10, 8'h00, 8'hA1, 8'hA1, 4'd2},  // R2 load miss
    '{LD, 8'h10, 8'h00, CN,  8'h00, 8'h00, 8'h00, 8'hA1, 4'd5},  // R5 shared hit
    '{ST, 8'h10, 8'h5B, CIV, 8'h10, 8'h00, 8'h00, 8'h00, 4'd4},  // R4 upgrade
    '{LD, 8'h10, 8'h00, CN,  8'h00, 8'h00, 8'h00, 8'h5B, 4'd5},  // R5 modified hit
    '{ST, 8'h10, 8'h6C, CN,  8'h00, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 store hit
    '{LD, 8'h10, 8'h00, CN,  8'h00, 8'h00, 8'h00, 8'h6C, 4'd5},
    '{ST, 8'h21, 8'h77, CRX, 8'h21, 8'h00, 8'h00, 8'h00, 4'd3},  // R3 store miss
    '{LD, 8'h21, 8'h00, CN,  8'h00, 8'h00, 8'h00, 8'h77, 4'd3},
    '{EV, 8'h21, 8'h00, CWB, 8'h21, 8'h77, 8'h00, 8'h00, 4'd7},  // R7 dirty evict
    '{LD, 8'h21, 8'h00, CRD, 8'h21, 8'h00, 8'h33, 8'h33, 4'd7},
    '{EV, 8'h21, 8'h00, CN,  8'h00, 8'h00, 8'h00, 8'h00, 4'd6},  // R6 silent evict
    '{LD, 8'h21, 8'h00, CRD, 8'h21, 8'h00, 8'h44, 8'h44, 4'd6},
    '{EV, 8'h22, 8'h00, CN,  8'h00, 8'h00, 8'h00, 8'h00, 4'd6}
  };

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cpuReq = 1'b0; busGnt = 1'b0; snpValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runOp(input logic [1:0] op, input logic [7:0] addr, input logic [7:0] wd,
                       input logic [2:0] cmd, input logic [7:0] bAddr, input logic [7:0] bData,
                       input logic [7:0] rep, input logic [7:0] rd, input string req);
    logic [2:0] nxt;
    @(negedge clk);
    cpuReq = 1'b1; cpuOp = op; cpuAddr = addr; cpuWdata = wd;
    #1;
    if (cmd == CN) begin
      check(req, "immediate done/busReq", {14'd0, cpuDone, busReq}, 16'b10);
    end else begin
      check(req, "no early done", {15'd0, cpuDone}, 16'd0);
      @(negedge clk);
      check(req, "busReq", {15'd0, busReq}, 16'd1);
      busGnt = 1'b1;
      #1;
      check(req, "issued cmd", {5'd0, busOutValid, busOutCmd, busOutAddr}, {5'd0, 1'b1, cmd, bAddr});
      if (cmd == CWB) check(req, "write-back data", {8'd0, busOutData}, {8'd0, bData});
      nxt = cmd;
      if ((cmd == CWB) && (op != EV)) begin
        check(req, "victim not done", {15'd0, cpuDone}, 16'd0);
        @(negedge clk);
        busGnt = 1'b0;
        #1;
        check(req, "busReq after victim", {15'd0, busReq}, 16'd1);
        nxt = (op == LD) ? CRD : CRX;
        busGnt = 1'b1;
        #1;
        check(req, "fetch after victim", {5'd0, busOutValid, busOutCmd, busOutAddr}, {5'd0, 1'b1, nxt, addr});
      end
      if ((nxt == CRD) || (nxt == CRX)) begin
        @(negedge clk);
        busGnt = 1'b0;
        snpValid = 1'b1; snpCmd = CRP; snpAddr = addr; snpData = rep;
        #1;
      end
      check(req, "done", {15'd0, cpuDone}, 16'd1);
    end
    if (op == LD) check(req, "load data", {8'd0, cpuRdata}, {8'd0, rd});
    @(negedge clk);
    cpuReq = 1'b0; busGnt = 1'b0; snpValid = 1'b0;
  endtask

  task automatic snoopOp(input logic [2:0] cmd, input logic [7:0] addr, input logic expRep,
                         input logic [7:0] expData, input string req);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = addr; snpData = 8'hEE;
    #1;
    check(req, "reply/owner", {14'd0, busOutValid, busOwner}, {14'd0, expRep, expRep});
    if (expRep) check(req, "reply fields", {1'b0, busOutCmd, busOutAddr, busOutData[3:0]},
                      {1'b0, CRP, addr, expData[3:0]});
    if (expRep) check(req, "reply data", {8'd0, busOutData}, {8'd0, expData});
    @(negedge clk);
    snpValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    doReset();
    #1;
    // R1: idle outputs after reset
    check("R1", "idle outputs", {12'd0, cpuDone, busReq, busOutValid, busOwner}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].cmd, VECS[i].bAddr,
            VECS[i].bData, VECS[i].rep, VECS[i].rd, $sformatf("R%0d", VECS[i].req));
    end

    // R13: dirty victim written back before the fetch
    runOp(LD, 8'h14, 8'h00, CWB, 8'h10, 8'h6C, 8'h99, 8'h99, "R13");
    runOp(LD, 8'h14, 8'h00, CN,  8'h00, 8'h00, 8'h00, 8'h99, "R13");

    // R8: owner reply on snooped read, line then Shared
    runOp(ST, 8'h03, 8'hD3, CRX, 8'h03, 8'h00, 8'h00, 8'h00, "R3");
    snoopOp(CRD, 8'h03, 1'b1, 8'hD3, "R8");
    runOp(ST, 8'h03, 8'hE4, CIV, 8'h03, 8'h00, 8'h00, 8'h00, "R8");

    // R9: owner reply on snooped read-exclusive, line then Invalid
    snoopOp(CRX, 8'h03, 1'b1, 8'hE4, "R9");
    runOp(LD, 8'h03, 8'h00, CRD, 8'h03, 8'h00, 8'h55, 8'h55, "R9");

    // R10: shared copy dropped silently
    snoopOp(CIV, 8'h03, 1'b0, 8'h00, "R10");
    runOp(LD, 8'h03, 8'h00, CRD, 8'h03, 8'h00, 8'h56, 8'h56, "R10");
    snoopOp(CRX, 8'h03, 1'b0, 8'h00, "R10");
    runOp(LD, 8'h03, 8'h00, CRD, 8'h03, 8'h00, 8'h57, 8'h57, "R10");

    // R11: mismatched tags leave lines alone
    snoopOp(CRD, 8'h07, 1'b0, 8'h00, "R11");
    snoopOp(CRX, 8'h83, 1'b0, 8'h00, "R11");
    snoopOp(CIV, 8'h43, 1'b0, 8'h00, "R11");
    runOp(LD, 8'h03, 8'h00, CN, 8'h00, 8'h00, 8'h00, 8'h57, "R11");
    runOp(ST, 8'h03, 8'hC8, CIV, 8'h03, 8'h00, 8'h00, 8'h00, "R11");
    snoopOp(CRX, 8'h83, 1'b0, 8'h00, "R11");
    snoopOp(CRD, 8'h02, 1'b0, 8'h00, "R11");
    runOp(LD, 8'h03, 8'h00, CN, 8'h00, 8'h00, 8'h00, 8'hC8, "R11");

    // R12: upgrade loses the bus to a peer invalidate
    runOp(LD, 8'h0D, 8'h00, CRD, 8'h0D, 8'h00, 8'h12, 8'h12, "R12");
    @(negedge clk);
    cpuReq = 1'b1; cpuOp = ST; cpuAddr = 8'h0D; cpuWdata = 8'h9E;
    @(negedge clk);
    #1;
    check("R12", "upgrade requests bus", {15'd0, busReq}, 16'd1);
    snpValid = 1'b1; snpCmd = CIV; snpAddr = 8'h0D;
    #1;
    check("R12", "no reply to peer invalidate", {15'd0, busOutValid}, 16'd0);
    @(negedge clk);
    snpValid = 1'b0;
    busGnt = 1'b1;
    #1;
    check("R12", "restart as read-exclusive", {4'd0, busOutValid, busOutCmd, busOutAddr}, {4'd0, 1'b1, CRX, 8'h0D});
    check("R12", "not done at grant", {15'd0, cpuDone}, 16'd0);
    @(negedge clk);
    busGnt = 1'b0;
    snpValid = 1'b1; snpCmd = CRP; snpAddr = 8'h0D; snpData = 8'h34;
    #1;
    check("R12", "done on reply", {15'd0, cpuDone}, 16'd1);
    @(negedge clk);
    cpuReq = 1'b0; snpValid = 1'b0;
    snoopOp(CRD, 8'h0D, 1'b1, 8'h9E, "R12");

    // R1: reset mid-run clears every line
    doReset();
    #1;
    check("R1", "idle after second reset", {12'd0, cpuDone, busReq, busOutValid, busOwner}, 16'd0);
    snoopOp(CRD, 8'h03, 1'b0, 8'h00, "R1");
    runOp(LD, 8'h03, 8'h00, CRD, 8'h03, 8'h00, 8'h21, 8'h21, "R1");

    summary();
    $finish;
  end

endmodule